// File: doc/BRIEF.md
# Register-Programmed SPI Master with Per-Character Chip-Select Control

This block is a serial peripheral interface master driven through a 32-bit register port. Software writes one word per character to the transmit register. That word carries the 8-bit character, the number of the chip select to use and a flag that keeps the chip select asserted once the character ends. A one-entry holding buffer sits in front of the shifter, so the next character can be queued while the current one is still on the wire. A held chip select then runs straight into the next character with no extra SCK gap.

The serial clock is the module clock divided by a programmable prescale. The clock idle level and the capture edge are selectable, and so is the bit order. Two programmable delays, counted in module clocks, set how long the chip select leads the first clock edge and how long it trails the last one. Each chip select has a programmable inactive level. Only the chip select named in the current character ever leaves that level.

Received characters land in a one-entry receive register. Its status word shows whether new data is present and whether the holding buffer is occupied. Reading the status word consumes the received character.

Top module: `spim_top`

## Requirements
- R1: After the reset input, all chip selects read 1, SCK is 0, and the receive/status register (offset 0x40) returns bit 31 = 1 (no new data) and bit 29 = 0 (holding buffer free).
- R2: While bit 24 of the control register (offset 0x04) is 0, no character starts. A queued character stays in the holding buffer (status bit 29 = 1) and starts once bit 24 is set.
- R3: A write to offset 0x3C queues bits 7:0 as the character, bits 17:16 as the chip-select number and bit 28 as the hold flag. Format bit 20 (offset 0x50) selects the bit order: 0 sends the MSB first and 1 sends the LSB first. The character received in the same order reads back in status bits 7:0.
- R4: Format bit 17 sets the SCK idle level. Format bit 16 = 0 captures MISO on the leading (first) edge of each bit and changes MOSI on the trailing edge. Bit 16 = 1 changes MOSI on the leading edge and captures on the trailing edge.
- R5: With prescale P in format bits 15:8 and P' = P, or 1 when P = 0, one SCK period is P'+1 module clocks. The level after the leading edge lasts floor((P'+1)/2) clocks and the idle level before it lasts ceil((P'+1)/2) clocks.
- R6: With setup value C in delay register bits 31:24 (offset 0x48), the first leading edge comes C+1+ceil((P'+1)/2) clocks after the chip select asserts. With hold value T in bits 23:16, a chip select released at the end of a character rises T+1 clocks after the last trailing edge.
- R7: A character whose hold flag is 1 leaves its chip select asserted after it ends. A flag of 0 releases the chip select after the hold delay.
- R8: If the hold flag is 1 and the next character for the same chip select is already queued, the next character's first leading edge follows the last trailing edge by exactly the idle-level half period.
- R9: Status bit 29 is 1 while the holding buffer is occupied, and a transmit write in that state is dropped. Status bit 31 reads 0 once a character has completed and returns to 1 after the status register is read. A newer character overwrites an unread one.
- R10: Bit n of the idle-level register (offset 0x4C, reset value all ones) is the level of chip select n whenever it is not the selected, asserted chip select. At most one chip select differs from its idle level at any time.
- R11: Writing 0 to bit 0 of the run register (offset 0x00) empties the holding and receive buffers and releases the chip select, and a character discarded this way is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (consumes receive data at 0x40) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Chip selects, active low |

## Verification
A wrong shift counter or phase flag shows up within one character: the bench's serial slave captures a different byte, or the status register returns one. A stuck holding-buffer flag shows up in the status read made right after a write, and as a character that never appears, or one too many, on the wire. A fault in the delay or half-period counters changes the edge spacing, and the bench measures that spacing in whole clocks on every character. A fault in chip-select selection is caught on the first clock in which a non-selected line leaves its idle level.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int unsigned REG_AW = 8;
    localparam int unsigned REG_DW = 32;

    localparam logic [REG_AW-1:0] OFS_RUN  = 8'h00;
    localparam logic [REG_AW-1:0] OFS_CTL  = 8'h04;
    localparam logic [REG_AW-1:0] OFS_TX   = 8'h3C;
    localparam logic [REG_AW-1:0] OFS_STAT = 8'h40;
    localparam logic [REG_AW-1:0] OFS_DLY  = 8'h48;
    localparam logic [REG_AW-1:0] OFS_IDLE = 8'h4C;
    localparam logic [REG_AW-1:0] OFS_FMT  = 8'h50;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_BITS,
        ST_HOLD
    } spim_state_e;

    typedef struct packed {
        logic       lsb;
        logic       pol;
        logic       pha;
        logic [7:0] pre;
        logic [7:0] setup;
        logic [7:0] hold;
    } spim_cfg_t;
endpackage

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int unsigned NCS    = 4,
    parameter int unsigned CHAR_W = 8,
    localparam int unsigned CSW   = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [REG_AW-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    output logic [REG_DW-1:0] rdata,
    input  logic              tx_full,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    output spim_cfg_t         cfg,
    output logic              run,
    output logic              enable,
    output logic [NCS-1:0]    idle_lvl,
    output logic              tx_push,
    output logic [CHAR_W-1:0] tx_data,
    output logic [CSW-1:0]    tx_cs,
    output logic              tx_hold,
    output logic              rx_pop
);
    typedef struct packed {
        logic           run;
        logic           master;
        logic           intclk;
        logic           en;
        spim_cfg_t      cfg;
        logic [NCS-1:0] idle;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            unique case (addr)
                OFS_RUN:  r_d.run = wdata[0];
                OFS_CTL:  begin
                    r_d.master = wdata[0];
                    r_d.intclk = wdata[1];
                    r_d.en     = wdata[24];
                end
                OFS_DLY:  begin
                    r_d.cfg.setup = wdata[31:24];
                    r_d.cfg.hold  = wdata[23:16];
                end
                OFS_IDLE: r_d.idle = wdata[NCS-1:0];
                OFS_FMT:  begin
                    r_d.cfg.pre = wdata[15:8];
                    r_d.cfg.pha = wdata[16];
                    r_d.cfg.pol = wdata[17];
                    r_d.cfg.lsb = wdata[20];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.idle <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_RUN:  rdata[0] = r_q.run;
            OFS_CTL:  begin
                rdata[0]  = r_q.master;
                rdata[1]  = r_q.intclk;
                rdata[24] = r_q.en;
            end
            OFS_STAT: begin
                rdata[31]         = ~rx_valid;
                rdata[29]         = tx_full;
                rdata[CHAR_W-1:0] = rx_data;
            end
            OFS_DLY:  rdata[31:16] = {r_q.cfg.setup, r_q.cfg.hold};
            OFS_IDLE: rdata[NCS-1:0] = r_q.idle;
            OFS_FMT:  begin
                rdata[4:0]  = 5'(CHAR_W);
                rdata[15:8] = r_q.cfg.pre;
                rdata[16]   = r_q.cfg.pha;
                rdata[17]   = r_q.cfg.pol;
                rdata[20]   = r_q.cfg.lsb;
            end
            default: ;
        endcase
    end

    assign cfg      = r_q.cfg;
    assign run      = r_q.run;
    assign enable   = r_q.run & r_q.en;
    assign idle_lvl = r_q.idle;
    assign tx_push  = wr && (addr == OFS_TX) && r_q.run;
    assign tx_data  = wdata[CHAR_W-1:0];
    assign tx_cs    = wdata[16 +: CSW];
    assign tx_hold  = wdata[28];
    assign rx_pop   = rd && (addr == OFS_STAT);
endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int unsigned NCS    = 4,
    parameter int unsigned CHAR_W = 8,
    localparam int unsigned CSW   = (NCS > 1) ? $clog2(NCS) : 1,
    localparam int unsigned HALVES = 2 * CHAR_W,
    localparam int unsigned HW    = $clog2(HALVES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              enable,
    input  spim_cfg_t         cfg,
    input  logic [NCS-1:0]    idle_lvl,
    input  logic              push,
    input  logic [CHAR_W-1:0] push_data,
    input  logic [CSW-1:0]    push_cs,
    input  logic              push_hold,
    input  logic              pop,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic [NCS-1:0]    cs_n,
    output logic              tx_full,
    output logic              tx_load,
    output logic              rx_valid,
    output logic [CHAR_W-1:0] rx_data,
    output logic              char_done,
    output logic              busy,
    output logic              cs_act
);
    typedef struct packed {
        spim_state_e       st;
        logic [7:0]        cnt;
        logic [HW-1:0]     half;
        logic [CHAR_W-1:0] txsr;
        logic [CHAR_W-1:0] rxsr;
        logic [CSW-1:0]    cur_cs;
        logic              cur_hold;
        logic              cs_on;
        logic              hb_full;
        logic [CHAR_W-1:0] hb_data;
        logic [CSW-1:0]    hb_cs;
        logic              hb_hold;
        logic              rx_valid;
        logic [CHAR_W-1:0] rx_data;
    } eng_t;

    eng_t q, n;
    logic [7:0]        pre_eff;
    logic [8:0]        per, e_len, o_len;
    logic [7:0]        elen_m1, olen_m1;
    logic [CHAR_W-1:0] rx_new;
    logic              load, done;

    always_comb begin
        pre_eff = (cfg.pre == 8'd0) ? 8'd1 : cfg.pre;
        per     = {1'b0, pre_eff} + 9'd1;
        e_len   = (per + 9'd1) >> 1;
        o_len   = per >> 1;
        elen_m1 = e_len[7:0] - 8'd1;
        olen_m1 = o_len[7:0] - 8'd1;
    end

    always_comb begin
        n      = q;
        load   = 1'b0;
        done   = 1'b0;
        rx_new = q.rxsr;
        if (pop) n.rx_valid = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (q.hb_full && enable) begin
                    load       = 1'b1;
                    n.cur_cs   = q.hb_cs;
                    n.cur_hold = q.hb_hold;
                    n.txsr     = q.hb_data;
                    n.half     = '0;
                    if (q.cs_on && q.cur_cs == q.hb_cs) begin
                        n.st  = ST_BITS;
                        n.cnt = elen_m1;
                    end else begin
                        n.cs_on = 1'b1;
                        n.st    = ST_SETUP;
                        n.cnt   = cfg.setup;
                    end
                end
            end
            ST_SETUP: begin
                if (q.cnt == 8'd0) begin
                    n.st  = ST_BITS;
                    n.cnt = elen_m1;
                end else begin
                    n.cnt = q.cnt - 8'd1;
                end
            end
            ST_BITS: begin
                if (q.cnt != 8'd0) begin
                    n.cnt = q.cnt - 8'd1;
                end else begin
                    if (q.half[0] == cfg.pha)
                        rx_new = cfg.lsb ? {miso, q.rxsr[CHAR_W-1:1]}
                                         : {q.rxsr[CHAR_W-2:0], miso};
                    n.rxsr = rx_new;
                    if (cfg.pha ? (!q.half[0] && q.half != '0) : q.half[0])
                        n.txsr = cfg.lsb ? (q.txsr >> 1) : (q.txsr << 1);
                    if (q.half == HW'(HALVES - 1)) begin
                        done       = 1'b1;
                        n.rx_data  = rx_new;
                        n.rx_valid = 1'b1;
                        n.half     = '0;
                        if (q.cur_hold && q.hb_full && q.hb_cs == q.cur_cs && enable) begin
                            load       = 1'b1;
                            n.txsr     = q.hb_data;
                            n.cur_hold = q.hb_hold;
                            n.cnt      = elen_m1;
                        end else if (q.cur_hold) begin
                            n.st = ST_IDLE;
                        end else begin
                            n.st  = ST_HOLD;
                            n.cnt = cfg.hold;
                        end
                    end else begin
                        n.half = q.half + HW'(1);
                        n.cnt  = q.half[0] ? elen_m1 : olen_m1;
                    end
                end
            end
            ST_HOLD: begin
                if (q.cnt == 8'd0) begin
                    n.cs_on = 1'b0;
                    n.st    = ST_IDLE;
                end else begin
                    n.cnt = q.cnt - 8'd1;
                end
            end
            default: n.st = ST_IDLE;
        endcase
        if (load) n.hb_full = 1'b0;
        if (push && (!q.hb_full || load)) begin
            n.hb_full = 1'b1;
            n.hb_data = push_data;
            n.hb_cs   = push_cs;
            n.hb_hold = push_hold;
        end
        if (!run) begin
            n.st       = ST_IDLE;
            n.cs_on    = 1'b0;
            n.hb_full  = 1'b0;
            n.rx_valid = 1'b0;
            n.half     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_n[i] = (q.cs_on && q.cur_cs == CSW'(i)) ? 1'b0 : idle_lvl[i];
    end

    assign sck       = cfg.pol ^ ((q.st == ST_BITS) & q.half[0]);
    assign mosi      = ((q.st == ST_SETUP) || (q.st == ST_BITS)) ?
                       (cfg.lsb ? q.txsr[0] : q.txsr[CHAR_W-1]) : 1'b0;
    assign tx_full   = q.hb_full;
    assign tx_load   = load;
    assign rx_valid  = q.rx_valid;
    assign rx_data   = q.rx_data;
    assign char_done = done;
    assign busy      = (q.st != ST_IDLE);
    assign cs_act    = q.cs_on;
endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int unsigned NCS    = 4,
    parameter int unsigned CHAR_W = 8,
    localparam int unsigned CSW   = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NCS-1:0]    spi_cs_n
);
    spim_cfg_t         cfg;
    logic              run, enable, tx_push, tx_hold, rx_pop;
    logic              tx_full, tx_load, rx_valid, char_done, busy, cs_act;
    logic [NCS-1:0]    idle_lvl;
    logic [CHAR_W-1:0] tx_data, rx_data;
    logic [CSW-1:0]    tx_cs;

    spim_regs #(.NCS(NCS), .CHAR_W(CHAR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .tx_full(tx_full),
        .rx_valid(rx_valid), .rx_data(rx_data), .cfg(cfg), .run(run),
        .enable(enable), .idle_lvl(idle_lvl), .tx_push(tx_push),
        .tx_data(tx_data), .tx_cs(tx_cs), .tx_hold(tx_hold), .rx_pop(rx_pop)
    );

    spim_engine #(.NCS(NCS), .CHAR_W(CHAR_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .run(run), .enable(enable), .cfg(cfg),
        .idle_lvl(idle_lvl), .push(tx_push), .push_data(tx_data),
        .push_cs(tx_cs), .push_hold(tx_hold), .pop(rx_pop), .miso(spi_miso),
        .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n), .tx_full(tx_full),
        .tx_load(tx_load), .rx_valid(rx_valid), .rx_data(rx_data),
        .char_done(char_done), .busy(busy), .cs_act(cs_act)
    );
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
    parameter int unsigned NCS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           run,
    input logic           enable,
    input logic           busy,
    input logic           cs_act,
    input logic [NCS-1:0] cs_n,
    input logic [NCS-1:0] idle_lvl,
    input logic           sck,
    input logic           pol,
    input logic           tx_full,
    input logic           rx_valid,
    input logic           rx_pop,
    input logic           char_done
);
    assert_one_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cs_n ^ idle_lvl) <= 1);

    assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |-> (sck == pol));

    assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !busy) |=> !busy);

    assert_pop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !char_done) |=> !rx_valid);

    assert_done_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> rx_valid);

    assert_softrst_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!tx_full && !rx_valid && !cs_act));
endmodule

bind spim_top spim_checker #(.NCS(NCS)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .enable(enable), .busy(busy),
    .cs_act(cs_act), .cs_n(spi_cs_n), .idle_lvl(idle_lvl), .sck(spi_sck),
    .pol(cfg.pol), .tx_full(tx_full), .rx_valid(rx_valid), .rx_pop(rx_pop),
    .char_done(char_done)
);

// File: tb/spim_top_bench.sv
`timescale 1ns/1ps
module spim_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;
    logic [3:0]  spi_cs_n;

    always #2.5 clk = ~clk;

    spim_top u_spim_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    int checks = 0, fails = 0;
    int cyc = 0;
    bit mon_on = 0;
    int exp_cs = 0;
    bit exp_pol = 0, exp_pha = 0, exp_lsb = 0;
    logic [3:0] exp_idle = 4'hF;

    logic [7:0] mb [16];
    int mi = 0, nchr = 0, bitn = 0;
    logic [7:0] cap = '0;
    logic [7:0] capq [$];
    bit prev_act = 0, prev_sck = 0, last_mosi = 0, first_lead = 0;
    int t_fall = 0, t_lead = 0, t_trail = 0;
    int setup_gap = -1, hold_gap = -1, b2b_gap = -1, hi_len = -1, lo_len = -1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic bit bitof(input logic [7:0] b, input int k, input bit lsb);
        return lsb ? b[k] : b[7-k];
    endfunction

    // Behavioural serial slave and per-clock reference checks
    always @(posedge clk) begin
        #1;
        cyc++;
        if (mon_on) begin
            bit act;
            act = (spi_cs_n[exp_cs] == 1'b0);
            for (int i = 0; i < 4; i++)
                if (i != exp_cs)
                    chk(spi_cs_n[i] == exp_idle[i], "R10 other cs at idle level", spi_cs_n[i], exp_idle[i]);
            if (!act)
                chk(spi_sck == exp_pol, "R4 sck idle level", spi_sck, exp_pol);
            if (act && !prev_act) begin
                bitn = 0; t_fall = cyc; first_lead = 1;
                if (!exp_pha) spi_miso = bitof(mb[mi], 0, exp_lsb);
            end
            if (act && spi_sck != prev_sck) begin
                if (spi_sck != exp_pol) begin
                    if (bitn == 0) begin
                        if (first_lead) setup_gap = cyc - t_fall;
                        else            b2b_gap = cyc - t_trail;
                        first_lead = 0;
                    end else begin
                        lo_len = cyc - t_trail;
                    end
                    t_lead = cyc;
                    if (!exp_pha) cap = exp_lsb ? {last_mosi, cap[7:1]} : {cap[6:0], last_mosi};
                    else          spi_miso = bitof(mb[mi], bitn, exp_lsb);
                end else begin
                    hi_len = cyc - t_lead;
                    t_trail = cyc;
                    if (exp_pha) cap = exp_lsb ? {last_mosi, cap[7:1]} : {cap[6:0], last_mosi};
                    bitn++;
                    if (bitn == 8) begin
                        capq.push_back(cap);
                        nchr++; mi++; bitn = 0;
                    end
                    if (!exp_pha) spi_miso = bitof(mb[mi], bitn, exp_lsb);
                end
            end
            if (!act && prev_act) hold_gap = cyc - t_trail;
            prev_act = act;
        end
        prev_sck  = spi_sck;
        last_mosi = spi_mosi;
    end

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #0.5 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_fmt(input int pre, input bit pha, input bit pol, input bit lsb);
        wr_reg(8'h50, (32'(lsb) << 20) | (32'(pol) << 17) | (32'(pha) << 16) | (32'(pre) << 8) | 32'd8);
        exp_pha = pha; exp_pol = pol; exp_lsb = lsb;
    endtask

    task automatic send(input int cs, input bit hold, input logic [7:0] d);
        wr_reg(8'h3C, (32'(hold) << 28) | (32'(cs) << 16) | 32'(d));
    endtask

    task automatic wait_release(input int n, input string tag);
        int t;
        t = 0;
        while (!(nchr >= n && spi_cs_n[exp_cs] == exp_idle[exp_cs]) && t < 4000) begin
            @(negedge clk); t++;
        end
        chk(t < 4000, tag, nchr, n);
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_cap(input logic [7:0] e, input string tag);
        logic [7:0] g;
        g = (capq.size() > 0) ? capq.pop_front() : 8'hxx;
        chk(g === e, tag, g, e);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired at cycle %0d expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base;
        for (int i = 0; i < 16; i++) mb[i] = 8'(8'h3C + i * 8'h27);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(spi_cs_n == 4'hF, "R1 cs after reset", spi_cs_n, 4'hF);
        chk(spi_sck == 1'b0, "R1 sck after reset", spi_sck, 0);
        rd_reg(8'h40, v);
        chk(v[31] == 1'b1, "R1 rx empty", v[31], 1);
        chk(v[29] == 1'b0, "R1 holding free", v[29], 0);

        wr_reg(8'h00, 32'd1);
        wr_reg(8'h48, (32'd3 << 24) | (32'd2 << 16));
        set_fmt(1, 0, 0, 0);
        wr_reg(8'h04, 32'd3);
        exp_cs = 0; mon_on = 1;

        // R2 gate, then R3/R5/R6/R9 in mode 0
        send(0, 0, 8'hA5);
        repeat (40) @(negedge clk);
        chk(nchr == 0, "R2 no transfer while disabled", nchr, 0);
        rd_reg(8'h40, v);
        chk(v[29] == 1'b1, "R2 queued char held", v[29], 1);
        wr_reg(8'h04, 32'h0100_0003);
        wait_release(1, "R2 transfer after enable");
        expect_cap(8'hA5, "R3 mosi char msb first");
        chk(setup_gap == 5, "R6 setup gap", setup_gap, 5);
        chk(hold_gap == 3, "R6 hold gap", hold_gap, 3);
        chk(hi_len == 1 && lo_len == 1, "R5 halves prescale 1", hi_len * 16 + lo_len, 17);
        rd_reg(8'h40, v);
        chk(v[7:0] == mb[0], "R3 received char", v[7:0], mb[0]);
        chk(v[31] == 1'b0, "R9 rx present", v[31], 0);
        rd_reg(8'h40, v);
        chk(v[31] == 1'b1, "R9 read clears rx", v[31], 1);

        // Mode 3, prescale 3, hold flag on cs1
        mon_on = 0; set_fmt(3, 1, 1, 0); exp_cs = 1; mon_on = 1;
        base = nchr;
        send(1, 1, 8'h5A);
        while (nchr < base + 1) @(negedge clk);
        repeat (30) @(negedge clk);
        chk(spi_cs_n[1] == 1'b0, "R7 cs held after char", spi_cs_n[1], 0);
        send(1, 0, 8'hC3);
        wait_release(base + 2, "R7 release after unheld char");
        expect_cap(8'h5A, "R4 mode3 first char");
        expect_cap(8'hC3, "R4 mode3 second char");
        chk(setup_gap == 6, "R6 setup gap prescale 3", setup_gap, 6);
        chk(hi_len == 2 && lo_len == 2, "R5 halves prescale 3", hi_len * 16 + lo_len, 34);
        rd_reg(8'h40, v);
        chk(v[7:0] == mb[base + 1], "R4 mode3 received", v[7:0], mb[base + 1]);

        // Mode 1, prescale 0, back-to-back and dropped write
        mon_on = 0; set_fmt(0, 1, 0, 0); exp_cs = 0; mon_on = 1;
        base = nchr;
        send(0, 1, 8'h96);
        do rd_reg(8'h40, v); while (v[29]);
        send(0, 0, 8'h69);
        rd_reg(8'h40, v);
        chk(v[29] == 1'b1, "R9 holding full", v[29], 1);
        send(0, 0, 8'hFF);
        wait_release(base + 2, "R8 pair done");
        repeat (60) @(negedge clk);
        chk(nchr == base + 2, "R9 write while full dropped", nchr, base + 2);
        expect_cap(8'h96, "R8 first char");
        expect_cap(8'h69, "R8 second char");
        chk(b2b_gap == 1, "R8 gap between held chars", b2b_gap, 1);
        chk(hi_len == 1 && lo_len == 1, "R5 prescale 0 as 1", hi_len * 16 + lo_len, 17);
        rd_reg(8'h40, v);
        chk(v[7:0] == mb[base + 1], "R9 newest char kept", v[7:0], mb[base + 1]);

        // Mode 2, prescale 2, LSB first, cs2, cs3 idle low
        mon_on = 0;
        set_fmt(2, 0, 1, 1);
        wr_reg(8'h4C, 32'h7);
        exp_idle = 4'b0111; exp_cs = 2;
        mon_on = 1;
        chk(spi_cs_n == 4'b0111, "R10 idle levels", spi_cs_n, 4'b0111);
        base = nchr;
        send(2, 0, 8'h1E);
        wait_release(base + 1, "R10 cs2 transfer");
        expect_cap(8'h1E, "R3 lsb first char");
        chk(hi_len == 1 && lo_len == 2, "R5 unequal halves", hi_len * 16 + lo_len, 18);
        rd_reg(8'h40, v);
        chk(v[7:0] == mb[base], "R3 lsb first received", v[7:0], mb[base]);

        // R11 soft reset
        base = nchr;
        wr_reg(8'h04, 32'd3);
        send(2, 1, 8'h33);
        wr_reg(8'h00, 32'd0);
        rd_reg(8'h40, v);
        chk(v[29] == 1'b0, "R11 holding cleared", v[29], 0);
        chk(v[31] == 1'b1, "R11 rx cleared", v[31], 1);
        wr_reg(8'h00, 32'd1);
        wr_reg(8'h04, 32'h0100_0003);
        repeat (80) @(negedge clk);
        chk(nchr == base, "R11 discarded char not sent", nchr, base);
        chk(spi_cs_n == 4'b0111, "R11 cs released", spi_cs_n, 4'b0111);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule